// File: doc/BRIEF.md
# Output Rounding, Limiting and Number-Format Stage

This stage sits at the tail of a filter datapath. It accepts a wide signed accumulator result together with a strobe that marks it as valid. It rounds the result to the nearest step of a resolution chosen at run time, with ties rounding upward. It clamps the rounded value to a signed range and writes it as a 16-bit word in one of two number formats. The word is held in an output register. An asynchronous enable can float the output pins, so several drivers can share a data bus.

The accumulator carries eight fraction bits below the least significant bit of the output word. A 3-bit rounding code sets how many of the 16 output bits stay significant, in steps of two. A 2-bit rate-mode input picks the clamp width. One rate-mode code clamps to a 15-bit signed range to protect against overflow. Every other code clamps to the full 16 bits.

Top module: `ofmt_stage`

## Requirements
- R1: While `rst_ni` is low, and after it is released, the output register holds 16'h0000 until the first accepted result.
- R2: The accumulator is read as a signed value A in units of 1/256 of an output LSB. Rounding code n (0..7) gives, before limiting, floor((A + 2^(7+2n)) / 2^(8+2n)) * 2^(2n), measured in output LSBs. A tie therefore rounds toward plus infinity.
- R3: In two's complement form, the low 2n bits of the output word are always zero, where n is the rounding code used for that result.
- R4: In every rate mode except 2'b00, a rounded value above 32767 becomes 16'h7FFF with its low 2n bits cleared. A rounded value below -32768 becomes 16'h8000.
- R5: With rate mode 2'b00, the clamp range is -16384..16383. An overflow gives 16'h3FFF with its low 2n bits cleared, and an underflow gives 16'hC000. Rate modes 2'b01, 2'b10 and 2'b11 pass 16384 as 16'h4000.
- R6: With `twos_sel_i` = 1 the word is two's complement. With `twos_sel_i` = 0 it is inverted offset binary: bit 15 equals the two's complement sign bit and bits 14:0 are the inverse of the two's complement bits. So zero reads as 16'h7FFF and -1 reads as 16'h8000.
- R7: The output register loads the formatted word on a rising clock edge where `acc_valid_i` is 1, and becomes visible after that edge. On an edge where `acc_valid_i` is 0 it keeps its value.
- R8: While `oe_ni` is 1 the output pins are high impedance, with no clock needed. `oe_ni` has no effect on what the register stores.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock, rising edge active |
| rst_ni | input | 1 | Asynchronous reset, active low |
| acc_i | input | 24 | Signed accumulator result, 8 fraction bits below output LSB |
| acc_valid_i | input | 1 | Marks `acc_i` as a new result to register |
| rate_mode_i | input | 2 | Rate mode; 2'b00 selects the 15-bit clamp |
| rnd_code_i | input | 3 | Rounding code n; keeps 16-2n significant bits |
| twos_sel_i | input | 1 | 1: two's complement, 0: inverted offset binary |
| oe_ni | input | 1 | Output enable, active low, asynchronous |
| data_o | output | 16 | Registered output word, tristated when disabled |

## Verification
The assertions check these properties on every clock:
- The register holds when the strobe is low, and loads the formatted word when it is high.
- The two clamp flags are never raised together.
- A clamped word carries the sign of its overflow direction.
- No limited word in the narrow mode leaves the 15-bit range.
- The bits below the selected resolution are zero.
- The sign bit survives both format conversions.

The rounding arithmetic itself can only be shown by the bench scenarios. These compare the output against hand-worked values for tie cases, negative floors, every clamp boundary in both limit widths, and both number formats. The same goes for the asynchronous tristate, and for the fact that the enable leaves the stored value alone.

// File: rtl/ofmt_pkg.sv
package ofmt_pkg;

  localparam int ACC_W_DEF = 24;  // accumulator width
  localparam int OUT_W_DEF = 16;  // output word width
  localparam int RND_W_DEF = 3;   // rounding code width
  localparam int STEP_DEF  = 2;   // bits dropped per rounding code step

  typedef enum logic [1:0] {
    RATE_NARROW = 2'b00,
    RATE_DOWN   = 2'b01,
    RATE_UP     = 2'b10,
    RATE_EQUAL  = 2'b11
  } rate_mode_e;

  typedef enum logic {
    FMT_OFFS_INV = 1'b0,
    FMT_TWOS     = 1'b1
  } fmt_e;

endpackage

// File: rtl/ofmt_round.sv
module ofmt_round #(
  parameter int ACC_W = ofmt_pkg::ACC_W_DEF,
  parameter int OUT_W = ofmt_pkg::OUT_W_DEF,
  parameter int RND_W = ofmt_pkg::RND_W_DEF,
  parameter int STEP  = ofmt_pkg::STEP_DEF,
  localparam int SHW  = OUT_W + 1
) (
  input  logic signed [ACC_W-1:0] acc_i,
  input  logic [RND_W-1:0]        code_i,
  output logic signed [SHW-1:0]   scaled_o
);

  localparam int FRAC_W = ACC_W - OUT_W;
  localparam int NCODE  = 1 << RND_W;
  localparam int SUM_W  = ACC_W + 1;

  // Round at code c: add half of the kept LSB, floor, then clear the dropped bits.
  function automatic logic signed [SHW-1:0] round_at(input logic signed [ACC_W-1:0] a,
                                                     input int c);
    logic signed [SUM_W-1:0] s;
    logic signed [SUM_W-1:0] half;
    half = SUM_W'(1) <<< (FRAC_W + STEP*c - 1);
    s = SUM_W'(a) + half;
    s = s >>> (FRAC_W + STEP*c);
    s = s <<< (STEP*c);
    return s[SHW-1:0];
  endfunction

  logic signed [SHW-1:0] cand [NCODE];

  for (genvar c = 0; c < NCODE; c++) begin : g_code
    assign cand[c] = round_at(acc_i, c);
  end

  assign scaled_o = cand[code_i];

endmodule

// File: rtl/ofmt_limit.sv
module ofmt_limit #(
  parameter int OUT_W = ofmt_pkg::OUT_W_DEF,
  parameter int RND_W = ofmt_pkg::RND_W_DEF,
  parameter int STEP  = ofmt_pkg::STEP_DEF,
  localparam int SHW  = OUT_W + 1
) (
  input  logic signed [SHW-1:0] scaled_i,
  input  logic                  narrow_i,
  input  logic [RND_W-1:0]      code_i,
  output logic [OUT_W-1:0]      word_o,
  output logic                  sat_hi_o,
  output logic                  sat_lo_o
);

  localparam logic signed [SHW-1:0] MAX_WIDE   = SHW'((1 << (OUT_W-1)) - 1);
  localparam logic signed [SHW-1:0] MIN_WIDE   = -SHW'(1 << (OUT_W-1));
  localparam logic signed [SHW-1:0] MAX_NARROW = SHW'((1 << (OUT_W-2)) - 1);
  localparam logic signed [SHW-1:0] MIN_NARROW = -SHW'(1 << (OUT_W-2));

  function automatic logic [OUT_W-1:0] low_mask(input logic [RND_W-1:0] c);
    return (OUT_W'(1) << (STEP*int'(c))) - OUT_W'(1);
  endfunction

  logic signed [SHW-1:0] lim_max, lim_min;
  logic [OUT_W-1:0]      top_word;

  assign lim_max  = narrow_i ? MAX_NARROW : MAX_WIDE;
  assign lim_min  = narrow_i ? MIN_NARROW : MIN_WIDE;
  assign sat_hi_o = scaled_i > lim_max;
  assign sat_lo_o = scaled_i < lim_min;
  assign top_word = lim_max[OUT_W-1:0] & ~low_mask(code_i);

  always_comb begin
    if (sat_hi_o)      word_o = top_word;
    else if (sat_lo_o) word_o = lim_min[OUT_W-1:0];
    else               word_o = scaled_i[OUT_W-1:0];
  end

endmodule

// File: rtl/ofmt_format.sv
module ofmt_format #(
  parameter int OUT_W = ofmt_pkg::OUT_W_DEF
) (
  input  logic [OUT_W-1:0] word_i,
  input  logic             twos_i,
  output logic [OUT_W-1:0] word_o
);

  // Offset binary flips the sign bit; inverting every bit of that keeps the
  // sign bit and inverts the rest.
  function automatic logic [OUT_W-1:0] to_offs_inv(input logic [OUT_W-1:0] w);
    return {w[OUT_W-1], ~w[OUT_W-2:0]};
  endfunction

  assign word_o = (twos_i == ofmt_pkg::FMT_TWOS) ? word_i : to_offs_inv(word_i);

endmodule

// File: rtl/ofmt_stage.sv
module ofmt_stage #(
  parameter int ACC_W = ofmt_pkg::ACC_W_DEF,
  parameter int OUT_W = ofmt_pkg::OUT_W_DEF,
  parameter int RND_W = ofmt_pkg::RND_W_DEF,
  parameter int STEP  = ofmt_pkg::STEP_DEF,
  parameter logic [1:0] NARROW_CODE = ofmt_pkg::RATE_NARROW
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [ACC_W-1:0] acc_i,
  input  logic             acc_valid_i,
  input  logic [1:0]       rate_mode_i,
  input  logic [RND_W-1:0] rnd_code_i,
  input  logic             twos_sel_i,
  input  logic             oe_ni,
  output logic [OUT_W-1:0] data_o
);

  localparam int SHW = OUT_W + 1;

  // Named internal events, observed by the bound checker.
  logic signed [SHW-1:0] scaled_word;
  logic                  narrow_sel;
  logic [OUT_W-1:0]      lim_word;
  logic                  sat_hi, sat_lo;
  logic [OUT_W-1:0]      fmt_word;
  logic [OUT_W-1:0]      out_q;

  assign narrow_sel = (rate_mode_i == NARROW_CODE);

  ofmt_round #(.ACC_W(ACC_W), .OUT_W(OUT_W), .RND_W(RND_W), .STEP(STEP)) u_round (
    .acc_i    (signed'(acc_i)),
    .code_i   (rnd_code_i),
    .scaled_o (scaled_word)
  );

  ofmt_limit #(.OUT_W(OUT_W), .RND_W(RND_W), .STEP(STEP)) u_limit (
    .scaled_i (scaled_word),
    .narrow_i (narrow_sel),
    .code_i   (rnd_code_i),
    .word_o   (lim_word),
    .sat_hi_o (sat_hi),
    .sat_lo_o (sat_lo)
  );

  ofmt_format #(.OUT_W(OUT_W)) u_format (
    .word_i (lim_word),
    .twos_i (twos_sel_i),
    .word_o (fmt_word)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)          out_q <= '0;
    else if (acc_valid_i) out_q <= fmt_word;
  end

  assign data_o = oe_ni ? {OUT_W{1'bz}} : out_q;

endmodule

// File: rtl/ofmt_stage_chk.sv
module ofmt_stage_chk #(
  parameter int OUT_W = ofmt_pkg::OUT_W_DEF,
  parameter int RND_W = ofmt_pkg::RND_W_DEF,
  parameter int STEP  = ofmt_pkg::STEP_DEF
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             acc_valid_i,
  input logic [RND_W-1:0] rnd_code_i,
  input logic             twos_sel_i,
  input logic             narrow_sel,
  input logic [OUT_W-1:0] lim_word,
  input logic             sat_hi,
  input logic             sat_lo,
  input logic [OUT_W-1:0] fmt_word,
  input logic [OUT_W-1:0] out_q
);

  logic [OUT_W-1:0] drop_bits;
  assign drop_bits = (OUT_W'(1) << (STEP*int'(rnd_code_i))) - OUT_W'(1);

  p_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc_valid_i |=> $stable(out_q));

  p_load_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    acc_valid_i |=> out_q == $past(fmt_word));

  p_no_overflow_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    narrow_sel |-> lim_word[OUT_W-1] == lim_word[OUT_W-2]);

  p_one_side_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({sat_hi, sat_lo}));

  p_hi_positive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_hi |-> !lim_word[OUT_W-1]);

  p_lo_negative_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sat_lo |-> lim_word[OUT_W-1]);

  p_low_zero_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (lim_word & drop_bits) == '0);

  p_sign_kept_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fmt_word[OUT_W-1] == lim_word[OUT_W-1]);

  p_twos_pass_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    twos_sel_i |-> fmt_word == lim_word);

endmodule

bind ofmt_stage ofmt_stage_chk #(.OUT_W(OUT_W), .RND_W(RND_W), .STEP(STEP)) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .acc_valid_i (acc_valid_i),
  .rnd_code_i  (rnd_code_i),
  .twos_sel_i  (twos_sel_i),
  .narrow_sel  (narrow_sel),
  .lim_word    (lim_word),
  .sat_hi      (sat_hi),
  .sat_lo      (sat_lo),
  .fmt_word    (fmt_word),
  .out_q       (out_q)
);

// File: tb/ofmt_stage_test.sv
`timescale 1ns/1ps
module ofmt_stage_test;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [23:0] acc = '0;
  logic        valid = 1'b0;
  logic [1:0]  mode = 2'b01;
  logic [2:0]  rnd = '0;
  logic        tc = 1'b1;
  logic        oe_n = 1'b0;
  wire  [15:0] data_o;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  ofmt_stage uut (
    .clk_i(clk), .rst_ni(rst_n), .acc_i(acc), .acc_valid_i(valid),
    .rate_mode_i(mode), .rnd_code_i(rnd), .twos_sel_i(tc), .oe_ni(oe_n),
    .data_o(data_o)
  );

  // {acc[45:22], rnd[21:19], mode[18:17], tc[16], expected[15:0]}
  localparam int NV = 18;
  localparam logic [45:0] VEC [NV] = '{
    {24'h001234, 3'd0, 2'b01, 1'b1, 16'h0012},  // R2 plain rounding
    {24'h000080, 3'd0, 2'b01, 1'b1, 16'h0001},  // R2 tie rounds up
    {24'hFFFF80, 3'd0, 2'b01, 1'b1, 16'h0000},  // R2 negative tie
    {24'hFFFF7F, 3'd0, 2'b01, 1'b1, 16'hFFFF},  // R2 negative floor
    {24'h001234, 3'd1, 2'b01, 1'b1, 16'h0014},  // R2 R3 code 1
    {24'h200000, 3'd7, 2'b01, 1'b1, 16'h4000},  // R2 R3 code 7
    {24'hFFDFFF, 3'd3, 2'b01, 1'b1, 16'hFFC0},  // R3 masked negative
    {24'h7FFFFF, 3'd0, 2'b01, 1'b1, 16'h7FFF},  // R4 positive clamp
    {24'h7FFFFF, 3'd1, 2'b01, 1'b1, 16'h7FFC},  // R4 clamp at code 1
    {24'h800000, 3'd0, 2'b01, 1'b1, 16'h8000},  // R4 most negative
    {24'h400000, 3'd0, 2'b00, 1'b1, 16'h3FFF},  // R5 narrow high
    {24'h800000, 3'd0, 2'b00, 1'b1, 16'hC000},  // R5 narrow low
    {24'h400000, 3'd2, 2'b00, 1'b1, 16'h3FF0},  // R5 narrow at code 2
    {24'h400000, 3'd0, 2'b10, 1'b1, 16'h4000},  // R5 wide mode 10
    {24'h000000, 3'd0, 2'b11, 1'b0, 16'h7FFF},  // R6 zero inverted offset
    {24'h001234, 3'd1, 2'b01, 1'b0, 16'h7FEB},  // R6 positive inverted
    {24'hFFFF7F, 3'd0, 2'b01, 1'b0, 16'h8000},  // R6 minus one inverted
    {24'h800000, 3'd0, 2'b01, 1'b0, 16'hFFFF}   // R6 most negative inverted
  };

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic load(input logic [23:0] a, input logic [2:0] r, input logic [1:0] m,
                      input logic t);
    @(negedge clk);
    acc = a; rnd = r; mode = m; tc = t; valid = 1'b1;
    @(posedge clk); #1;
    valid = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset held", data_o, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release", data_o, 16'h0000);

    for (int i = 0; i < NV; i++) begin
      load(VEC[i][45:22], VEC[i][21:19], VEC[i][18:17], VEC[i][16]);
      check($sformatf("R2-R6 vector %0d", i), data_o, VEC[i][15:0]);
    end

    // R7: no strobe, value held
    load(24'h001234, 3'd0, 2'b01, 1'b1);
    @(negedge clk);
    acc = 24'h7FFFFF; valid = 1'b0;
    repeat (3) @(posedge clk);
    #1 check("R7 hold without strobe", data_o, 16'h0012);
    // R7 latency: not visible before the edge
    @(negedge clk);
    valid = 1'b1;
    #1 check("R7 before edge", data_o, 16'h0012);
    @(posedge clk); #1;
    valid = 1'b0;
    check("R7 after edge", data_o, 16'h7FFF);

    // R8: disable floats pins without a clock edge
    #1 oe_n = 1'b1;
    #0.5 check("R8 pins released", (data_o === 16'h7FFF) ? 16'h0001 : 16'h0000, 16'h0000);
    load(24'h000080, 3'd0, 2'b01, 1'b1);
    #0.5 oe_n = 1'b0;
    #0.5 check("R8 load while disabled", data_o, 16'h0001);

    // R1: reset again clears the register
    @(negedge clk);
    rst_n = 1'b0;
    #1 check("R1 mid-run reset", data_o, 16'h0000);
    @(negedge clk);
    rst_n = 1'b1;

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_vec++;
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

endmodule